// File: doc/BRIEF.md
# Command-Sequence Write Guard

This unit sits between a host's byte-write stream and a non-volatile array's write controller. It decides for each host write whether the byte may be stored. It watches every write's address and data for two fixed command sequences. A three-write sequence turns protection on. While protection is on, the same three writes also unlock one load. A six-write sequence turns protection off.

Writes that arrive within a fixed window of one another form one load. When the window passes with no write, the load closes and a programming period starts. The controller is busy for that period and reads return polling status. A load with protection on and no unlock still runs the programming period, but none of its bytes is stored. A new protection state takes effect at the edge where the programming period after its command ends.

The protection flag is cleared only by the power-on reset. The ordinary reset clears the matcher and the timers and leaves the flag alone.

Top module: `wp_guard`

## Requirements
- R1: While `powerOnN` is low, `protectOn` reads 0. After both resets, `progBusy` reads 0.
- R2: With protection off, an ordinary write is permitted in its own cycle. `wrPermit` is 1 and `cmdByte` is 0. This holds for the command addresses too when they carry non-command data, for example 0x5555 with 0x12.
- R3: Each byte of the enable sequence is flagged `cmdByte`=1 and `wrPermit`=0. The enable sequence is address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0.
- R4: A load closes once LOAD_WINDOW clock edges pass with no accepted write after its last write. `progBusy` rises at that edge and stays high for exactly PROG_CYCLES cycles.
- R5: A completed enable or disable sequence changes `protectOn` only at the edge where `progBusy` falls after that load. During the busy period `protectOn` keeps its old value.
- R6: With protection on, a write not preceded by the sequence in the same load is refused (`wrPermit`=0, `cmdByte`=0). The load still runs a full programming period.
- R7: With protection on, writes that follow the complete enable sequence in the same load are permitted. They are not matched as commands, even when they look like command bytes. Protection stays on.
- R8: A write that breaks a partly matched sequence returns the matcher to idle and is handled as an ordinary write. A later byte that would have completed the sequence is then ordinary as well.
- R9: A partly matched sequence is dropped when its load closes. Its closing byte, sent after the programming period, is handled as an ordinary write.
- R10: All six bytes of the disable sequence are flagged `cmdByte`=1. After the programming period of that load, `protectOn` is 0. The disable sequence is 0x5555 with 0xAA, 0x2AAA with 0x55, 0x5555 with 0x80, 0x5555 with 0xAA, 0x2AAA with 0x55, then 0x5555 with 0x20.
- R11: Writes presented while `progBusy` is 1 are ignored. `wrPermit` and `cmdByte` stay 0. The writes neither open a load nor advance the matcher.
- R12: Pulsing `rstN` alone leaves `protectOn` unchanged. Pulsing `powerOnN` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of matcher and timers |
| powerOnN | input | 1 | Active-low asynchronous power-on reset of the protection flag |
| wrValid | input | 1 | Host byte write present this cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| wrPermit | output | 1 | This write may be stored (combinational) |
| cmdByte | output | 1 | This write is a command byte and must not be stored (combinational) |
| progBusy | output | 1 | Programming period running |
| protectOn | output | 1 | Protection state |

## Verification
The matcher is driven with several patterns. A clean enable sequence and a clean disable sequence check the command flags. A sequence broken by a foreign byte and a sequence split by a load timeout tell apart a matcher that really returns to idle from one that only skips a byte. Writes are sent while protection is on with and without the unlock prefix, which separates blocked stores from unlocked ones. A command-looking byte after the unlock shows that unlocked data is no longer matched. Writes during the busy period are followed by a later continuation of the sequence; this shows that busy-time bytes left no trace in the matcher or the load timer. The edge at which the busy period starts and ends is checked cycle by cycle against both window lengths.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_AA,
    M_AA55,
    M_DIS_80,
    M_DIS_AA,
    M_DIS_55
  } matchState_t;

  // strobes from the sequence control to the state datapath
  typedef struct packed {
    logic takeWrite;
    logic armEnable;
    logic armDisable;
  } wpStrobe_t;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  CODE_LEAD  = 8'hAA;
  localparam logic [7:0]  CODE_SECOND = 8'h55;
  localparam logic [7:0]  CODE_ENABLE = 8'hA0;
  localparam logic [7:0]  CODE_DIS_A  = 8'h80;
  localparam logic [7:0]  CODE_DIS_B  = 8'h20;

endpackage

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progBusy,
  input  logic              loadExpire,
  input  logic              protectOn,
  output wpStrobe_t         strobe,
  output logic              wrPermit,
  output logic              cmdByte
);

  matchState_t state, nextState;
  logic unlocked;
  logic accept, hitA, hitB;
  logic isLead, isSecond, isEnable, isDisA, isDisB;
  logic stepHit, seqEnable, seqDisable;

  assign accept   = wrValid && !progBusy;
  assign hitA     = (wrAddr == ADDR_W'(CMD_ADDR_A));
  assign hitB     = (wrAddr == ADDR_W'(CMD_ADDR_B));
  assign isLead   = hitA && (wrData == DATA_W'(CODE_LEAD));
  assign isSecond = hitB && (wrData == DATA_W'(CODE_SECOND));
  assign isEnable = hitA && (wrData == DATA_W'(CODE_ENABLE));
  assign isDisA   = hitA && (wrData == DATA_W'(CODE_DIS_A));
  assign isDisB   = hitA && (wrData == DATA_W'(CODE_DIS_B));

  always_comb begin
    nextState  = state;
    stepHit    = 1'b0;
    seqEnable  = 1'b0;
    seqDisable = 1'b0;
    if (!unlocked) begin
      case (state)
        M_IDLE: begin
          if (isLead) begin
            stepHit   = 1'b1;
            nextState = M_AA;
          end
        end
        M_AA: begin
          if (isSecond) begin
            stepHit   = 1'b1;
            nextState = M_AA55;
          end else begin
            nextState = M_IDLE;
          end
        end
        M_AA55: begin
          if (isEnable) begin
            stepHit   = 1'b1;
            seqEnable = 1'b1;
            nextState = M_IDLE;
          end else if (isDisA) begin
            stepHit   = 1'b1;
            nextState = M_DIS_80;
          end else begin
            nextState = M_IDLE;
          end
        end
        M_DIS_80: begin
          if (isLead) begin
            stepHit   = 1'b1;
            nextState = M_DIS_AA;
          end else begin
            nextState = M_IDLE;
          end
        end
        M_DIS_AA: begin
          if (isSecond) begin
            stepHit   = 1'b1;
            nextState = M_DIS_55;
          end else begin
            nextState = M_IDLE;
          end
        end
        M_DIS_55: begin
          if (isDisB) begin
            stepHit    = 1'b1;
            seqDisable = 1'b1;
          end
          nextState = M_IDLE;
        end
        default: nextState = M_IDLE;
      endcase
    end
  end

  assign cmdByte  = accept && stepHit;
  assign wrPermit = accept && !stepHit && (!protectOn || unlocked);

  assign strobe.takeWrite  = accept;
  assign strobe.armEnable  = accept && seqEnable;
  assign strobe.armDisable = accept && seqDisable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= M_IDLE;
      unlocked <= 1'b0;
    end else if (loadExpire) begin
      state    <= M_IDLE;
      unlocked <= 1'b0;
    end else if (accept) begin
      state <= nextState;
      if (seqEnable || seqDisable) unlocked <= 1'b1;
    end
  end

endmodule

// File: rtl/wp_state_path.sv
module wp_state_path
  import wp_guard_pkg::*;
#(
  parameter int LOAD_WINDOW = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerOnN,
  input  wpStrobe_t strobe,
  output logic      loadExpire,
  output logic      progBusy,
  output logic      protectOn
);

  localparam int GAP_W  = $clog2(LOAD_WINDOW + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(LOAD_WINDOW - 1);
  localparam logic [PROG_W-1:0] PROG_ONE = PROG_W'(1);

  logic [GAP_W-1:0]  gapCnt;
  logic [PROG_W-1:0] progCnt;
  logic loadOpen, pendValid, pendOn;

  assign loadExpire = loadOpen && !strobe.takeWrite && (gapCnt == GAP_LAST);
  assign progBusy   = (progCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      loadOpen  <= 1'b0;
      progCnt   <= '0;
      pendValid <= 1'b0;
      pendOn    <= 1'b0;
    end else begin
      if (strobe.takeWrite) begin
        gapCnt   <= '0;
        loadOpen <= 1'b1;
      end else if (loadExpire) begin
        gapCnt   <= '0;
        loadOpen <= 1'b0;
      end else if (loadOpen) begin
        gapCnt <= gapCnt + 1'b1;
      end

      if (loadExpire) begin
        progCnt <= PROG_W'(PROG_CYCLES);
      end else if (progCnt != '0) begin
        progCnt <= progCnt - 1'b1;
        if (progCnt == PROG_ONE) pendValid <= 1'b0;
      end

      if (strobe.armEnable) begin
        pendValid <= 1'b1;
        pendOn    <= 1'b1;
      end else if (strobe.armDisable) begin
        pendValid <= 1'b1;
        pendOn    <= 1'b0;
      end
    end
  end

  // held across the ordinary reset, cleared only at power-on
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      protectOn <= 1'b0;
    end else if (progCnt == PROG_ONE && pendValid) begin
      protectOn <= pendOn;
    end
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int LOAD_WINDOW = 16,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOnN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrPermit,
  output logic              cmdByte,
  output logic              progBusy,
  output logic              protectOn
);

  wpStrobe_t strobe;
  logic loadExpire;

  wp_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .progBusy(progBusy), .loadExpire(loadExpire), .protectOn(protectOn),
    .strobe(strobe), .wrPermit(wrPermit), .cmdByte(cmdByte)
  );

  wp_state_path #(.LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)) u_path (
    .clk(clk), .rstN(rstN), .powerOnN(powerOnN), .strobe(strobe),
    .loadExpire(loadExpire), .progBusy(progBusy), .protectOn(protectOn)
  );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic clk,
  input logic rstN,
  input logic powerOnN,
  input logic wrValid,
  input logic wrPermit,
  input logic cmdByte,
  input logic progBusy,
  input logic protectOn
);

  assert_por_clear_R1: assert property (@(posedge clk) !powerOnN |-> !protectOn);

  assert_cmd_not_stored_R3: assert property (@(posedge clk) disable iff (!rstN || !powerOnN)
    !(wrPermit && cmdByte));

  assert_load_close_idle_R4: assert property (@(posedge clk) disable iff (!rstN || !powerOnN)
    $rose(progBusy) |-> !$past(wrValid));

  assert_flag_at_end_R5: assert property (@(posedge clk) disable iff (!rstN || !powerOnN)
    !$stable(protectOn) |-> $fell(progBusy));

  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rstN || !powerOnN)
    progBusy |-> (!wrPermit && !cmdByte));

endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .powerOnN(powerOnN), .wrValid(wrValid),
  .wrPermit(wrPermit), .cmdByte(cmdByte), .progBusy(progBusy), .protectOn(protectOn)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;

  localparam int W = 16;
  localparam int P = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerOnN = 1'b0;
  logic wrValid = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic wrPermit, cmdByte, progBusy, protectOn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wp_guard #(.ADDR_W(15), .DATA_W(8), .LOAD_WINDOW(W), .PROG_CYCLES(P)) uut (
    .clk(clk), .rstN(rstN), .powerOnN(powerOnN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .wrPermit(wrPermit), .cmdByte(cmdByte),
    .progBusy(progBusy), .protectOn(protectOn)
  );

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [7:0] d,
                         input int expPermit, input int expCmd, input string req);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    #1;
    checkVal(req, "wrPermit", int'(wrPermit), expPermit);
    checkVal(req, "cmdByte", int'(cmdByte), expCmd);
    @(posedge clk);
    #1;
    wrValid = 1'b0;
  endtask

  task automatic finishLoad();
    waitEdges(W + P);
  endtask

  // cycle-exact close and programming period after the last write
  task automatic checkLoadTiming(input string req, input int protBefore, input int protAfter);
    waitEdges(W - 1);
    checkVal("R4", "progBusy before close", int'(progBusy), 0);
    waitEdges(1);
    checkVal("R4", "progBusy at close", int'(progBusy), 1);
    waitEdges(P - 1);
    checkVal("R4", "progBusy last cycle", int'(progBusy), 1);
    checkVal(req, "protectOn during busy", int'(protectOn), protBefore);
    waitEdges(1);
    checkVal("R4", "progBusy after period", int'(progBusy), 0);
    checkVal(req, "protectOn after busy", int'(protectOn), protAfter);
  endtask

  task automatic t_reset();
    #1;
    checkVal("R1", "protectOn in reset", int'(protectOn), 0);
    @(negedge clk);
    rstN = 1'b1; powerOnN = 1'b1;
    waitEdges(2);
    checkVal("R1", "progBusy after reset", int'(progBusy), 0);
    checkVal("R1", "protectOn after reset", int'(protectOn), 0);
  endtask

  task automatic t_plain();
    doWrite(15'h0100, 8'h3C, 1, 0, "R2");
    doWrite(15'h5555, 8'h12, 1, 0, "R2");
    doWrite(15'h2AAA, 8'hAB, 1, 0, "R2");
    finishLoad();
    checkVal("R2", "protectOn", int'(protectOn), 0);
  endtask

  task automatic t_mismatch();
    doWrite(15'h5555, 8'hAA, 0, 1, "R8");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R8");
    doWrite(15'h1234, 8'h77, 1, 0, "R8");
    doWrite(15'h5555, 8'hA0, 1, 0, "R8");
    finishLoad();
    checkVal("R8", "protectOn", int'(protectOn), 0);
  endtask

  task automatic t_enable();
    doWrite(15'h5555, 8'hAA, 0, 1, "R3");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R3");
    doWrite(15'h5555, 8'hA0, 0, 1, "R3");
    checkLoadTiming("R5", 0, 1);
  endtask

  task automatic t_blocked();
    doWrite(15'h0200, 8'h11, 0, 0, "R6");
    waitEdges(W - 1);
    checkVal("R6", "progBusy before close", int'(progBusy), 0);
    waitEdges(1);
    checkVal("R6", "progBusy after blocked load", int'(progBusy), 1);
    waitEdges(P);
    checkVal("R6", "progBusy done", int'(progBusy), 0);
    checkVal("R6", "protectOn", int'(protectOn), 1);
  endtask

  task automatic t_busyIgnore();
    doWrite(15'h0210, 8'h22, 0, 0, "R6");
    waitEdges(W);
    checkVal("R11", "busy started", int'(progBusy), 1);
    doWrite(15'h0211, 8'h33, 0, 0, "R11");
    doWrite(15'h5555, 8'hAA, 0, 0, "R11");
    waitEdges(P - 3);
    checkVal("R11", "busy not extended", int'(progBusy), 1);
    waitEdges(1);
    checkVal("R11", "busy ends on time", int'(progBusy), 0);
    waitEdges(W + 2);
    checkVal("R11", "no load opened", int'(progBusy), 0);
    doWrite(15'h2AAA, 8'h55, 0, 0, "R11");
    finishLoad();
  endtask

  task automatic t_unlock();
    doWrite(15'h5555, 8'hAA, 0, 1, "R7");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R7");
    doWrite(15'h5555, 8'hA0, 0, 1, "R7");
    doWrite(15'h0300, 8'h5A, 1, 0, "R7");
    doWrite(15'h5555, 8'hAA, 1, 0, "R7");
    finishLoad();
    checkVal("R7", "protectOn", int'(protectOn), 1);
  endtask

  task automatic t_expire();
    doWrite(15'h5555, 8'hAA, 0, 1, "R9");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R9");
    finishLoad();
    doWrite(15'h5555, 8'hA0, 0, 0, "R9");
    finishLoad();
    checkVal("R9", "protectOn", int'(protectOn), 1);
  endtask

  task automatic t_disable();
    doWrite(15'h5555, 8'hAA, 0, 1, "R10");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R10");
    doWrite(15'h5555, 8'h80, 0, 1, "R10");
    doWrite(15'h5555, 8'hAA, 0, 1, "R10");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R10");
    doWrite(15'h5555, 8'h20, 0, 1, "R10");
    checkLoadTiming("R10", 1, 0);
    doWrite(15'h0400, 8'h44, 1, 0, "R10");
    finishLoad();
  endtask

  task automatic t_resets();
    doWrite(15'h5555, 8'hAA, 0, 1, "R12");
    doWrite(15'h2AAA, 8'h55, 0, 1, "R12");
    doWrite(15'h5555, 8'hA0, 0, 1, "R12");
    finishLoad();
    checkVal("R12", "protectOn armed", int'(protectOn), 1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkVal("R12", "protectOn after rstN", int'(protectOn), 1);
    checkVal("R12", "progBusy after rstN", int'(progBusy), 0);
    @(negedge clk);
    powerOnN = 1'b0;
    #1;
    checkVal("R12", "protectOn after powerOnN", int'(protectOn), 0);
    @(negedge clk);
    powerOnN = 1'b1;
    doWrite(15'h0500, 8'h55, 1, 0, "R12");
    finishLoad();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_mismatch();
    t_enable();
    t_blocked();
    t_busyIgnore();
    t_unlock();
    t_expire();
    t_disable();
    t_resets();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule